// File: doc/BRIEF.md
# Split Direct-Mapped Word Cache

This block places two small direct-mapped caches, one serving instruction fetches and one serving data accesses, in front of a plain memory port. Every line holds one 32-bit word plus a virtual word tag and a valid flag. A request carries a virtual address, a physical address, an access size, a load/store flag, a cacheable flag and an instruction/data selector. Loads that hit answer on the cycle after acceptance. Every other access goes out on the memory port through a ready/valid handshake.

The caches are write-through with no write allocate. A store never places its data in a line. It only drops the line it hits. Only full-word cacheable load misses bring a line in. Two mode inputs alter the lookup. The isolate mode makes every lookup count as a hit. The swap mode sends data accesses to the instruction array and instruction accesses to the data array. The block takes one request at a time and holds `req_ready` low until the current request has finished.

Top module: `split_word_cache`

## Requirements
- R1: A synchronous active-high `rst` clears every valid flag, so the first cacheable word load to any address after reset misses. During and just after reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0.
- R2: A line is selected by physical address bits [IDX_W+1:2], using the index width of the addressed array. A cacheable load hits when that line is valid and its tag equals `req_vaddr[31:2]`. A hit sets `rsp_valid` and `rsp_hit` to 1 on the cycle after acceptance and makes no memory request.
- R3: A cacheable word load (`req_size`=2) that misses issues one memory read. The returned word, the virtual tag and a set valid flag are written into the line, so a repeated load of that word hits with the same data.
- R4: Byte (`req_size`=0) and halfword (`req_size`=1) loads that miss are served from memory only. They leave the line unchanged, so a later word load of that address still misses.
- R5: Load data is extracted in little-endian lanes using `req_vaddr[1:0]`, for hits and for memory responses alike. A byte returns bits [8*off+7:8*off] zero-extended. A halfword returns bits [31:16] when `req_vaddr[1]` is 1 and bits [15:0] otherwise, zero-extended.
- R6: Every store, of any size, is sent to memory with its size, physical address and write data. If the store is cacheable and its lookup hits, the line becomes invalid. Store data never enters a line. A store is acknowledged by `rsp_valid` with `rsp_hit`=0 on the cycle after the memory accepts it.
- R7: When `req_cacheable` is 0 the arrays are neither read nor changed. The request goes to memory even if a matching line is valid, a load fills nothing, and a store invalidates nothing.
- R8: While `isolate_en` is 1, every cacheable lookup counts as a hit whatever the tag and valid state. A load returns the stored word of the indexed line without touching memory, and a store invalidates the indexed line.
- R9: While `swap_en` is 1, a data access (`req_instr`=0) uses the instruction array and an instruction access uses the data array, for lookup, fill and invalidation alike.
- R10: Tags are virtual. Two requests with the same physical index but different virtual word addresses do not hit on each other's line.
- R11: `mem_req_valid` stays at 1 with stable fields until `mem_req_ready` is seen. Each request makes at most one memory transaction. `req_ready` is 0 while a memory transaction is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| isolate_en | input | 1 | Force every cacheable lookup to hit |
| swap_en | input | 1 | Exchange the roles of the two arrays |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_instr | input | 1 | 1 = instruction access, 0 = data access |
| req_cacheable | input | 1 | Access may use the arrays |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_vaddr | input | 32 | Virtual address (tag and lane offset) |
| req_paddr | input | 32 | Physical address (index and memory address) |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Response was served from an array |
| rsp_data | output | 32 | Extracted load data, 0 for stores |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_store | output | 1 | Memory request is a write |
| mem_req_size | output | 2 | Access size forwarded to memory |
| mem_req_addr | output | 32 | Physical address to memory |
| mem_req_wdata | output | 32 | Write data to memory |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Aligned word holding the addressed bytes |

## Verification
The assertions watch the request and memory handshakes on every cycle. They check that memory requests stay stable until accepted and that no new request is taken while one is outstanding. They also check that stores and uncacheable accesses always reach memory, that isolated loads answer the next cycle without a memory request, and that byte results carry zero upper bits. Other behaviour depends on what the arrays hold, and only the bench's scenarios can show it. This covers fills only on word misses, invalidation after a hitting store, virtual-tag aliasing, isolated reads of invalidated lines and the array exchange under swap. The bench's reference model tracks every line and counts memory transactions per request to expose these.

// File: rtl/swc_pkg.sv
package swc_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 32;
    localparam int TAG_W  = ADDR_W - 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } swc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MREQ  = 2'd1,
        ST_MWAIT = 2'd2
    } swc_state_e;

    // little-endian lane pick, zero-extended
    function automatic logic [WORD_W-1:0] swc_lane(input logic [WORD_W-1:0] w,
                                                   input logic [1:0] sz,
                                                   input logic [1:0] off);
        logic [WORD_W-1:0] r;
        case (sz)
            SZ_BYTE: r = {24'b0, w[8*off +: 8]};
            SZ_HALF: r = {16'b0, w[16*off[1] +: 16]};
            default: r = w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/swc_line_store.sv
module swc_line_store
    import swc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic              inv_en,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [WORD_W-1:0] fill_word,
    output logic              lk_match,
    output logic [WORD_W-1:0] lk_word
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0]             valid;
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [DEPTH-1:0][WORD_W-1:0] word;
    } store_t;

    store_t arr_d, arr_q;

    always_comb begin
        arr_d = arr_q;
        if (inv_en) begin
            arr_d.valid[lk_idx] = 1'b0;
        end
        if (fill_en) begin
            arr_d.valid[fill_idx] = 1'b1;
            arr_d.tag[fill_idx]   = fill_tag;
            arr_d.word[fill_idx]  = fill_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_q.valid <= '0;
        end else begin
            arr_q <= arr_d;
        end
    end

    assign lk_match = arr_q.valid[lk_idx] && (arr_q.tag[lk_idx] == lk_tag);
    assign lk_word  = arr_q.word[lk_idx];

endmodule

// File: rtl/swc_steer.sv
module swc_steer
    import swc_pkg::*;
(
    input  logic                   sel_instr,
    input  logic                   isolate,
    input  logic [1:0]             match,
    input  logic [1:0][WORD_W-1:0] word,
    output logic                   hit,
    output logic [WORD_W-1:0]      hit_word
);

    // entry 0 is the data array, entry 1 the instruction array
    always_comb begin
        hit      = isolate || match[sel_instr];
        hit_word = word[sel_instr];
    end

endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl
    import swc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              swap,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic              req_instr,
    input  logic              req_cacheable,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] req_paddr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              lk_hit,
    input  logic [WORD_W-1:0] lk_word,
    output logic              lk_sel,
    output logic              inv_en,
    output logic              fill_en,
    output logic              fill_sel,
    output logic [ADDR_W-1:0] fill_vaddr,
    output logic [ADDR_W-1:0] fill_paddr,
    output logic [WORD_W-1:0] fill_word,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WORD_W-1:0] rsp_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_store,
    output logic [1:0]        mem_req_size,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data
);

    typedef struct packed {
        swc_state_e        state;
        logic              store;
        logic [1:0]        size;
        logic              sel;
        logic              fill;
        logic [ADDR_W-1:0] vaddr;
        logic [ADDR_W-1:0] paddr;
        logic [WORD_W-1:0] wdata;
        logic              rsp_valid;
        logic              rsp_hit;
        logic [WORD_W-1:0] rsp_data;
    } ctrl_t;

    ctrl_t c_d, c_q;

    assign lk_sel    = req_instr ^ swap;
    assign req_ready = (c_q.state == ST_IDLE);

    always_comb begin
        c_d           = c_q;
        c_d.rsp_valid = 1'b0;
        c_d.rsp_hit   = 1'b0;
        inv_en        = 1'b0;
        fill_en       = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.store = req_store;
                    c_d.size  = req_size;
                    c_d.sel   = lk_sel;
                    c_d.vaddr = req_vaddr;
                    c_d.paddr = req_paddr;
                    c_d.wdata = req_wdata;
                    c_d.fill  = 1'b0;
                    if (req_store) begin
                        inv_en    = req_cacheable && lk_hit;
                        c_d.state = ST_MREQ;
                    end else if (req_cacheable && lk_hit) begin
                        c_d.rsp_valid = 1'b1;
                        c_d.rsp_hit   = 1'b1;
                        c_d.rsp_data  = swc_lane(lk_word, req_size, req_vaddr[1:0]);
                    end else begin
                        c_d.fill  = req_cacheable && (req_size == SZ_WORD);
                        c_d.state = ST_MREQ;
                    end
                end
            end
            ST_MREQ: begin
                if (mem_req_ready) begin
                    if (c_q.store) begin
                        c_d.rsp_valid = 1'b1;
                        c_d.rsp_data  = '0;
                        c_d.state     = ST_IDLE;
                    end else begin
                        c_d.state = ST_MWAIT;
                    end
                end
            end
            ST_MWAIT: begin
                if (mem_rsp_valid) begin
                    fill_en       = c_q.fill;
                    c_d.rsp_valid = 1'b1;
                    c_d.rsp_data  = swc_lane(mem_rsp_data, c_q.size, c_q.vaddr[1:0]);
                    c_d.state     = ST_IDLE;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign fill_sel      = c_q.sel;
    assign fill_vaddr    = c_q.vaddr;
    assign fill_paddr    = c_q.paddr;
    assign fill_word     = mem_rsp_data;
    assign rsp_valid     = c_q.rsp_valid;
    assign rsp_hit       = c_q.rsp_hit;
    assign rsp_data      = c_q.rsp_data;
    assign mem_req_valid = (c_q.state == ST_MREQ);
    assign mem_req_store = c_q.store;
    assign mem_req_size  = c_q.size;
    assign mem_req_addr  = c_q.paddr;
    assign mem_req_wdata = c_q.wdata;

endmodule

// File: rtl/split_word_cache.sv
module split_word_cache
    import swc_pkg::*;
#(
    parameter int I_IDX_W = 4,
    parameter int D_IDX_W = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        isolate_en,
    input  logic        swap_en,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_store,
    input  logic        req_instr,
    input  logic        req_cacheable,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_vaddr,
    input  logic [31:0] req_paddr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic [31:0] rsp_data,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic        mem_req_store,
    output logic [1:0]  mem_req_size,
    output logic [31:0] mem_req_addr,
    output logic [31:0] mem_req_wdata,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data
);

    logic                   lk_sel, lk_hit, inv_en, fill_en, fill_sel;
    logic [WORD_W-1:0]      lk_word, fill_word;
    logic [ADDR_W-1:0]      fill_vaddr, fill_paddr;
    logic [1:0]             arr_match;
    logic [1:0][WORD_W-1:0] arr_word;

    // array 0 holds data lines, array 1 instruction lines
    for (genvar g = 0; g < 2; g++) begin : g_arr
        localparam int IW = (g == 0) ? D_IDX_W : I_IDX_W;
        swc_line_store #(.IDX_W(IW)) u_store (
            .clk      (clk),
            .rst      (rst),
            .lk_idx   (req_paddr[2 +: IW]),
            .lk_tag   (req_vaddr[ADDR_W-1:2]),
            .inv_en   (inv_en && (lk_sel == g[0])),
            .fill_en  (fill_en && (fill_sel == g[0])),
            .fill_idx (fill_paddr[2 +: IW]),
            .fill_tag (fill_vaddr[ADDR_W-1:2]),
            .fill_word(fill_word),
            .lk_match (arr_match[g]),
            .lk_word  (arr_word[g])
        );
    end

    swc_steer u_steer (
        .sel_instr(lk_sel),
        .isolate  (isolate_en),
        .match    (arr_match),
        .word     (arr_word),
        .hit      (lk_hit),
        .hit_word (lk_word)
    );

    swc_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .swap         (swap_en),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_store    (req_store),
        .req_instr    (req_instr),
        .req_cacheable(req_cacheable),
        .req_size     (req_size),
        .req_vaddr    (req_vaddr),
        .req_paddr    (req_paddr),
        .req_wdata    (req_wdata),
        .lk_hit       (lk_hit),
        .lk_word      (lk_word),
        .lk_sel       (lk_sel),
        .inv_en       (inv_en),
        .fill_en      (fill_en),
        .fill_sel     (fill_sel),
        .fill_vaddr   (fill_vaddr),
        .fill_paddr   (fill_paddr),
        .fill_word    (fill_word),
        .rsp_valid    (rsp_valid),
        .rsp_hit      (rsp_hit),
        .rsp_data     (rsp_data),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_store(mem_req_store),
        .mem_req_size (mem_req_size),
        .mem_req_addr (mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data)
    );

endmodule

// File: rtl/swc_checker.sv
module swc_checker (
    input logic        clk,
    input logic        rst,
    input logic        isolate_en,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_store,
    input logic        req_cacheable,
    input logic [1:0]  req_size,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [31:0] rsp_data,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_store,
    input logic [31:0] mem_req_addr
);

    logic acc;
    assign acc = req_valid && req_ready;

    a_r2_hit_is_response: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    a_r5_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (acc && !req_store && req_size == 2'd0) |=> (!rsp_valid || rsp_data[31:8] == 24'd0));

    a_r6_store_to_mem: assert property (@(posedge clk) disable iff (rst)
        (acc && req_store) |=> (mem_req_valid && mem_req_store));

    a_r7_bypass_to_mem: assert property (@(posedge clk) disable iff (rst)
        (acc && !req_cacheable) |=> (mem_req_valid && !rsp_valid));

    a_r8_isolate_hits: assert property (@(posedge clk) disable iff (rst)
        (acc && isolate_en && req_cacheable && !req_store) |=> (rsp_valid && rsp_hit && !mem_req_valid));

    a_r11_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_store)));

    a_r11_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

endmodule

bind split_word_cache swc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .isolate_en   (isolate_en),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_store    (req_store),
    .req_cacheable(req_cacheable),
    .req_size     (req_size),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_data     (rsp_data),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_store(mem_req_store),
    .mem_req_addr (mem_req_addr)
);

// File: tb/split_word_cache_test.sv
module split_word_cache_test;

    localparam int CLK_PERIOD = 10;
    localparam int I_IDX_W    = 4;
    localparam int D_IDX_W    = 3;
    localparam int WDOG       = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        isolate_en = 1'b0, swap_en = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0, req_instr = 1'b0, req_cacheable = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_vaddr = '0, req_paddr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_hit;
    logic [31:0] rsp_data;
    logic        mem_req_valid, mem_req_store;
    logic        mem_req_ready = 1'b0;
    logic [1:0]  mem_req_size;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_word_cache #(.I_IDX_W(I_IDX_W), .D_IDX_W(D_IDX_W)) uut (.*);

    int total = 0, bad = 0, cyc = 0;
    int mem_cnt = 0, mem_lat = 0, wait_cnt = 0;
    logic        last_store = 1'b0;
    logic [31:0] last_addr = '0, last_wdata = '0;
    logic [31:0] cur_pa = '0;
    bit          done = 0;

    typedef struct {
        logic [31:0] data;
        logic        hit;
        int          mem_before;
        logic        store;
        logic [31:0] wdata;
        int          rq;
    } exp_t;
    exp_t sb[$];

    // reference model: [0] data lines, [1] instruction lines
    logic        m_valid [2][16];
    logic [29:0] m_tag   [2][16];
    logic [31:0] m_word  [2][16];

    function automatic logic [31:0] mword(input logic [31:0] a);
        return ({2'b0, a[31:2]} * 32'h9E37_79B9) + 32'h0F1E_2D3C;
    endfunction

    function automatic logic [31:0] lane(input logic [31:0] w, input logic [1:0] sz, input logic [1:0] off);
        if (sz == 2'd0) return {24'b0, w[8*off +: 8]};
        if (sz == 2'd1) return {16'b0, w[16*off[1] +: 16]};
        return w;
    endfunction

    function automatic int midx(input logic s, input logic [31:0] pa);
        if (s) return int'(pa[2 +: I_IDX_W]);
        return int'(pa[2 +: D_IDX_W]);
    endfunction

    task automatic check(input bit ok, input int rq, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s got=%h exp=%h", rq, what, got, exp);
        end
    endtask

    task automatic issue(input bit instr, input bit st, input bit cab, input logic [1:0] sz,
                         input logic [31:0] va, input logic [31:0] pa, input logic [31:0] wd, input int rq);
        exp_t e;
        logic s;
        int   ix;
        bit   h;
        s  = instr ^ swap_en;
        ix = midx(s, pa);
        h  = cab && (isolate_en || (m_valid[s][ix] && m_tag[s][ix] == va[31:2]));
        e.mem_before = mem_cnt;
        e.store = st;
        e.wdata = wd;
        e.rq    = rq;
        if (st) begin
            e.data = '0; e.hit = 1'b0;
            if (h) m_valid[s][ix] = 1'b0;
        end else if (h) begin
            e.data = lane(m_word[s][ix], sz, va[1:0]); e.hit = 1'b1;
        end else begin
            e.data = lane(mword(pa), sz, va[1:0]); e.hit = 1'b0;
            if (cab && sz == 2'd2) begin
                m_valid[s][ix] = 1'b1; m_tag[s][ix] = va[31:2]; m_word[s][ix] = mword(pa);
            end
        end
        sb.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_pa = pa;
        req_valid = 1'b1; req_instr = instr; req_store = st; req_cacheable = cab;
        req_size = sz; req_vaddr = va; req_paddr = pa; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    // memory model
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (rst) begin
            mem_req_ready = 1'b0;
            wait_cnt = 0;
        end else if (mem_req_ready) begin
            mem_req_ready = 1'b0;
            if (!last_store) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mword(last_addr);
            end
        end else if (mem_req_valid) begin
            if (wait_cnt < mem_lat) wait_cnt++;
            else begin
                wait_cnt = 0;
                mem_req_ready = 1'b1;
                mem_cnt++;
                last_store = mem_req_store;
                last_addr  = mem_req_addr;
                last_wdata = mem_req_wdata;
                // R11: busy while outstanding, address forwarded unchanged
                check(!req_ready, 11, "req_ready while mem busy", {31'b0, req_ready}, 32'd0);
                check(mem_req_addr == cur_pa, 11, "mem address", mem_req_addr, cur_pa);
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, 11, "unexpected response", rsp_data, 32'd0);
            end else begin
                exp_t e;
                int   dm;
                e  = sb.pop_front();
                dm = e.hit ? 0 : 1;
                check(rsp_data == e.data, e.rq, "rsp_data", rsp_data, e.data);
                check(rsp_hit == e.hit, e.rq, "rsp_hit", {31'b0, rsp_hit}, {31'b0, e.hit});
                check((mem_cnt - e.mem_before) == dm, e.rq, "memory transactions",
                      mem_cnt - e.mem_before, dm);
                if (e.store)
                    check(last_store && last_wdata == e.wdata, e.rq, "store write data", last_wdata, e.wdata);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired got=%0d exp<=%0d", cyc, WDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 16; k++) begin
            m_valid[0][k] = 1'b0; m_valid[1][k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, 1, "req_ready in reset", {31'b0, req_ready}, 32'd1);
        check(rsp_valid == 1'b0, 1, "rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
        check(mem_req_valid == 1'b0, 1, "mem_req_valid in reset", {31'b0, mem_req_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && !rsp_valid && !mem_req_valid, 1, "idle after reset",
              {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'd4);

        // R1 R3: first word load misses and fills; R2 repeat hits
        issue(0, 0, 1, 2'd2, 32'h1000_0010, 32'h0000_0010, 0, 3);
        issue(0, 0, 1, 2'd2, 32'h1000_0010, 32'h0000_0010, 0, 2);
        // R5: byte and halfword lanes on hits
        for (int o = 0; o < 4; o++)
            issue(0, 0, 1, 2'd0, 32'h1000_0010 + o, 32'h0000_0010 + o, 0, 5);
        issue(0, 0, 1, 2'd1, 32'h1000_0010, 32'h0000_0010, 0, 5);
        issue(0, 0, 1, 2'd1, 32'h1000_0012, 32'h0000_0012, 0, 5);
        // R4: byte/half misses do not fill; R5 on memory path
        mem_lat = 2;
        issue(0, 0, 1, 2'd0, 32'h1000_0027, 32'h0000_0027, 0, 4);
        issue(0, 0, 1, 2'd1, 32'h1000_0026, 32'h0000_0026, 0, 4);
        issue(0, 0, 1, 2'd2, 32'h1000_0024, 32'h0000_0024, 0, 4);
        // R10: virtual alias on same index misses both ways
        issue(0, 0, 1, 2'd2, 32'h2000_0010, 32'h0000_0010, 0, 10);
        issue(0, 0, 1, 2'd2, 32'h1000_0010, 32'h0000_0010, 0, 10);
        // R7: uncacheable load bypasses a valid line, then line still hits
        mem_lat = 1;
        issue(0, 0, 0, 2'd2, 32'h1000_0010, 32'h0000_0010, 0, 7);
        issue(0, 0, 1, 2'd2, 32'h1000_0010, 32'h0000_0010, 0, 7);
        // R7: uncacheable store leaves the line valid
        issue(0, 1, 0, 2'd2, 32'h1000_0010, 32'h0000_0010, 32'hDEAD_BEEF, 7);
        issue(0, 0, 1, 2'd2, 32'h1000_0010, 32'h0000_0010, 0, 7);
        // R6: byte store invalidates hit line; data not cached
        issue(0, 1, 1, 2'd0, 32'h1000_0011, 32'h0000_0011, 32'h0000_00AB, 6);
        issue(0, 0, 1, 2'd2, 32'h1000_0010, 32'h0000_0010, 0, 6);
        // R6: halfword store to a missing line keeps other lines
        issue(0, 1, 1, 2'd1, 32'h1000_0034, 32'h0000_0034, 32'h0000_1234, 6);
        issue(0, 0, 1, 2'd2, 32'h1000_0010, 32'h0000_0010, 0, 6);
        // R8: isolate - invalidate, then isolated load still hits old word
        issue(0, 1, 1, 2'd2, 32'h1000_0010, 32'h0000_0010, 32'h5555_AAAA, 8);
        isolate_en = 1'b1;
        issue(0, 0, 1, 2'd2, 32'h3000_0010, 32'h0000_0010, 0, 8);
        issue(0, 0, 1, 2'd0, 32'h3000_0013, 32'h0000_0013, 0, 8);
        issue(0, 1, 1, 2'd2, 32'h7000_0024, 32'h0000_0024, 32'h0BAD_F00D, 8);
        isolate_en = 1'b0;
        issue(0, 0, 1, 2'd2, 32'h1000_0024, 32'h0000_0024, 0, 8);
        // R9: instruction fill, then swapped data access hits it
        mem_lat = 0;
        issue(1, 0, 1, 2'd2, 32'h0040_0100, 32'h0000_0100, 0, 9);
        issue(1, 0, 1, 2'd2, 32'h0040_0100, 32'h0000_0100, 0, 9);
        swap_en = 1'b1;
        issue(0, 0, 1, 2'd2, 32'h0040_0100, 32'h0000_0100, 0, 9);
        issue(1, 0, 1, 2'd2, 32'h1000_0024, 32'h0000_0024, 0, 9);
        issue(1, 0, 1, 2'd2, 32'h0040_0104, 32'h0000_0104, 0, 9);
        issue(0, 1, 1, 2'd2, 32'h0040_0100, 32'h0000_0100, 32'h1111_2222, 9);
        swap_en = 1'b0;
        issue(1, 0, 1, 2'd2, 32'h0040_0100, 32'h0000_0100, 0, 9);
        issue(0, 0, 1, 2'd2, 32'h0040_0104, 32'h0000_0104, 0, 9);
        // R11: long memory latency
        mem_lat = 3;
        issue(0, 0, 1, 2'd2, 32'h1000_0018, 32'h0000_0018, 0, 11);
        issue(0, 1, 1, 2'd2, 32'h1000_0018, 32'h0000_0018, 32'hCAFE_0001, 11);
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule